// File: doc/BRIEF.md
# Adaptive cut-through input port controller

This block sits on one input port of a two-dimensional mesh router and decides where each arriving packet goes. Flits come in over a valid/ready channel into a one-flit holding register. As soon as the first flit of a packet (the header, which carries the destination coordinates) is held, the controller compares those coordinates with the node's own address. It then starts asking the crossbar for an output, without waiting for the body of the packet.

The controller asks for one output per clock cycle, in a fixed order. It tries the productive horizontal channel first. It tries the productive vertical channel next, but only when the packet must still move in both dimensions. If every minimal output is refused, it does not wait for one to free up. It moves on at once to the local processing-node output, so that the node's interface can absorb the packet and send it back into the network later. A packet addressed to this node asks for the local output directly.

Once an output is granted, the connection is kept and the packet streams through at one flit per cycle. The controller counts flits against the fixed packet length and drops the connection after the last flit has left.

Top module: `acr_in_port_ctrl`

## Requirements
- R1: After reset no output is requested, no flit is forwarded, and the input channel is ready to take a header.
- R2: The header's destination is read with x in flit bits [5:3] and y in bits [2:0]. A request is raised in the cycle after the header is accepted. No further flit is accepted while the output is still being chosen.
- R3: When the destination x differs from the node x, the first request goes to east (request bit 0) if the destination x is larger, and to west (bit 1) if it is smaller.
- R4: When both offsets are nonzero and the first request is refused, the next cycle requests north (bit 2) if the destination y is larger, or south (bit 3) if it is smaller. When the x offset is zero, that vertical port is the first request. When the y offset is zero, no vertical port is ever requested.
- R5: When the last minimal request is refused, the next cycle requests the local port (bit 4). No minimal port is retried.
- R6: A packet whose destination equals the node address requests the local port first.
- R7: The local-port request is held every cycle until it is granted.
- R8: Once a request is granted, out_sel is one-hot on the granted port and the request stays on that port. All PKT_LEN flits of the packet leave on fwd_flit, one per cycle, in arrival order, starting with the header.
- R9: In the cycle after the last flit of a packet leaves, the request is dropped and the input is ready for the next header.
- R10: At most one request bit is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_x | input | 3 | X coordinate of this node |
| node_y | input | 3 | Y coordinate of this node |
| in_flit | input | 6 | Incoming flit |
| in_valid | input | 1 | Incoming flit is valid |
| in_ready | output | 1 | Controller accepts the incoming flit |
| out_req | output | 5 | Request to the output arbiters (bit 0 east, 1 west, 2 north, 3 south, 4 local) |
| out_gnt | input | 5 | Grants from the output arbiters, same bit order |
| out_sel | output | 5 | One-hot output chosen for the current connection |
| fwd_flit | output | 6 | Flit sent to the crossbar |
| fwd_valid | output | 1 | fwd_flit carries a flit of the connected packet |

## Verification
Four properties are checked on every cycle:
- at most one request is active;
- a forwarding connection keeps its request equal to the selected port;
- no flit is accepted while an output is being chosen;
- once the local port is requested, that request persists until the transfer begins.

Other behaviour can only be shown by the directed scenarios. These cover which port is tried in which order for each sign and zero case of the offsets, and the immediate fall-back to the local port. They also cover flit order and count through a connection, and the exact cycle at which the connection is released.

// File: rtl/acr_pkg.sv
package acr_pkg;
    parameter int COORD_W = 3;
    localparam int FLIT_W = 2 * COORD_W;
    localparam int NPORT  = 5;

    typedef enum logic [2:0] {
        PORT_EAST  = 3'd0,
        PORT_WEST  = 3'd1,
        PORT_NORTH = 3'd2,
        PORT_SOUTH = 3'd3,
        PORT_LOCAL = 3'd4
    } port_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TRY1,
        ST_TRY2,
        ST_EJECT,
        ST_XFER
    } conn_state_e;

    typedef struct packed {
        logic [COORD_W-1:0] x;
        logic [COORD_W-1:0] y;
    } coord_t;

    typedef struct packed {
        port_e first;
        port_e second;
        logic  has_second;
    } route_plan_t;

    function automatic logic [NPORT-1:0] port_onehot(port_e p);
        logic [NPORT-1:0] v;
        v = '0;
        v[p] = 1'b1;
        return v;
    endfunction

    // Minimal-path plan: horizontal first, vertical second, local when at home
    function automatic route_plan_t plan_route(coord_t dest, coord_t here);
        route_plan_t r;
        port_e ydir;
        ydir = (dest.y > here.y) ? PORT_NORTH : PORT_SOUTH;
        r.first      = PORT_LOCAL;
        r.second     = PORT_LOCAL;
        r.has_second = 1'b0;
        if (dest.x != here.x) begin
            r.first      = (dest.x > here.x) ? PORT_EAST : PORT_WEST;
            r.second     = ydir;
            r.has_second = (dest.y != here.y);
        end else if (dest.y != here.y) begin
            r.first = ydir;
        end
        return r;
    endfunction
endpackage

// File: rtl/acr_route_calc.sv
module acr_route_calc
    import acr_pkg::*;
(
    input  logic [FLIT_W-1:0] hdr_flit,
    input  coord_t            here,
    output route_plan_t       plan
);
    coord_t dest;

    assign dest = coord_t'(hdr_flit);
    assign plan = plan_route(dest, here);
endmodule

// File: rtl/acr_flit_stage.sv
module acr_flit_stage
    import acr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [FLIT_W-1:0] in_flit,
    input  logic              in_valid,
    input  logic              accept_en,
    input  logic              drain,
    output logic              in_ready,
    output logic [FLIT_W-1:0] buf_flit,
    output logic              buf_v
);
    logic fire;

    assign in_ready = accept_en && (!buf_v || drain);
    assign fire     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_v    <= 1'b0;
            buf_flit <= '0;
        end else if (fire) begin
            buf_v    <= 1'b1;
            buf_flit <= in_flit;
        end else if (drain) begin
            buf_v <= 1'b0;
        end
    end

    // R8
    hold_load_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> (buf_v && buf_flit == $past(in_flit)));
endmodule

// File: rtl/acr_conn_fsm.sv
module acr_conn_fsm
    import acr_pkg::*;
#(
    parameter int PKT_LEN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  route_plan_t      plan,
    input  logic             in_fire,
    input  logic             buf_v,
    input  logic [NPORT-1:0] gnt,
    output logic [NPORT-1:0] req,
    output logic [NPORT-1:0] sel,
    output logic             accept_en,
    output logic             drain
);
    localparam int CNT_W = $clog2(PKT_LEN + 1);

    conn_state_e      state;
    logic [CNT_W-1:0] rcv_cnt;
    logic [CNT_W-1:0] snd_cnt;
    logic [NPORT-1:0] sel_q;
    logic             won;

    assign won = |(gnt & req);
    assign sel = sel_q;

    always_comb begin
        req       = '0;
        accept_en = 1'b0;
        drain     = 1'b0;
        unique case (state)
            ST_IDLE:  accept_en = 1'b1;
            ST_TRY1:  req = port_onehot(plan.first);
            ST_TRY2:  req = port_onehot(plan.second);
            ST_EJECT: req = port_onehot(PORT_LOCAL);
            ST_XFER: begin
                req       = sel_q;
                accept_en = (rcv_cnt < CNT_W'(PKT_LEN));
                drain     = buf_v;
            end
            default: req = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            rcv_cnt <= '0;
            snd_cnt <= '0;
            sel_q   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (in_fire) begin
                        state   <= ST_TRY1;
                        rcv_cnt <= CNT_W'(1);
                        snd_cnt <= '0;
                    end
                end
                ST_TRY1: begin
                    if (won) begin
                        state <= ST_XFER;
                        sel_q <= req;
                    end else if (plan.has_second) begin
                        state <= ST_TRY2;
                    end else begin
                        state <= ST_EJECT;
                    end
                end
                ST_TRY2: begin
                    if (won) begin
                        state <= ST_XFER;
                        sel_q <= req;
                    end else begin
                        state <= ST_EJECT;
                    end
                end
                ST_EJECT: begin
                    if (won) begin
                        state <= ST_XFER;
                        sel_q <= req;
                    end
                end
                ST_XFER: begin
                    if (in_fire) rcv_cnt <= rcv_cnt + CNT_W'(1);
                    if (drain) begin
                        if (snd_cnt == CNT_W'(PKT_LEN - 1)) begin
                            state   <= ST_IDLE;
                            rcv_cnt <= '0;
                            snd_cnt <= '0;
                            sel_q   <= '0;
                        end else begin
                            snd_cnt <= snd_cnt + CNT_W'(1);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R10
    req_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req));

    // R8
    conn_hold_chk: assert property (@(posedge clk) disable iff (rst)
        drain |-> (req == sel && $onehot(sel)));

    // R2
    route_noaccept_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TRY1 || state == ST_TRY2 || state == ST_EJECT) |-> !in_fire);

    // R7
    eject_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EJECT) |=> req[PORT_LOCAL]);

    // R9
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (rcv_cnt <= CNT_W'(PKT_LEN)) && (snd_cnt < CNT_W'(PKT_LEN)));
endmodule

// File: rtl/acr_in_port_ctrl.sv
module acr_in_port_ctrl
    import acr_pkg::*;
#(
    parameter int PKT_LEN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [COORD_W-1:0] node_x,
    input  logic [COORD_W-1:0] node_y,
    input  logic [FLIT_W-1:0] in_flit,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [NPORT-1:0]  out_req,
    input  logic [NPORT-1:0]  out_gnt,
    output logic [NPORT-1:0]  out_sel,
    output logic [FLIT_W-1:0] fwd_flit,
    output logic              fwd_valid
);
    coord_t            here;
    route_plan_t       plan;
    logic [FLIT_W-1:0] buf_flit;
    logic              buf_v;
    logic              accept_en;
    logic              drain;
    logic              in_fire;

    assign here.x    = node_x;
    assign here.y    = node_y;
    assign in_fire   = in_valid && in_ready;
    assign fwd_flit  = buf_flit;
    assign fwd_valid = drain;

    acr_flit_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .in_flit   (in_flit),
        .in_valid  (in_valid),
        .accept_en (accept_en),
        .drain     (drain),
        .in_ready  (in_ready),
        .buf_flit  (buf_flit),
        .buf_v     (buf_v)
    );

    acr_route_calc u_route (
        .hdr_flit (buf_flit),
        .here     (here),
        .plan     (plan)
    );

    acr_conn_fsm #(.PKT_LEN(PKT_LEN)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .plan      (plan),
        .in_fire   (in_fire),
        .buf_v     (buf_v),
        .gnt       (out_gnt),
        .req       (out_req),
        .sel       (out_sel),
        .accept_en (accept_en),
        .drain     (drain)
    );
endmodule

// File: tb/sim_acr_in_port_ctrl.sv
module sim_acr_in_port_ctrl;
    localparam int PKT_LEN = 4;
    localparam logic [4:0] PE = 5'b00001, PW = 5'b00010, PN = 5'b00100,
                           PS = 5'b01000, PL = 5'b10000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] node_x = 3'd3;
    logic [2:0] node_y = 3'd3;
    logic [5:0] in_flit = '0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [4:0] out_req, out_gnt, out_sel;
    logic [5:0] fwd_flit;
    logic       fwd_valid;
    logic [4:0] free_now = '0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    assign out_gnt = out_req & free_now;

    acr_in_port_ctrl #(.PKT_LEN(PKT_LEN)) u0 (
        .clk(clk), .rst(rst), .node_x(node_x), .node_y(node_y),
        .in_flit(in_flit), .in_valid(in_valid), .in_ready(in_ready),
        .out_req(out_req), .out_gnt(out_gnt), .out_sel(out_sel),
        .fwd_flit(fwd_flit), .fwd_valid(fwd_valid)
    );

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    function automatic logic [5:0] flit_of(input logic [5:0] hdr, input int k);
        if (k == 0) return hdr;
        return 6'(k * 11 + 5);
    endfunction

    // Sends one packet; checks request trace, selection, data and release
    task automatic run_packet(input string rq, input logic [2:0] dx,
                              input logic [2:0] dy, input logic [4:0] free_mask,
                              input int pn_delay);
        logic [4:0] chain [4];
        int         nchain = 0;
        logic [4:0] exp_tr [32];
        int         exp_len = 0;
        logic [4:0] exp_sel = '0;
        logic [4:0] obs_tr [32];
        int         obs_len = 0;
        logic [4:0] sel_seen = '0;
        int         nfwd = 0;
        int         sent = 0;
        int         bad_data = 0;
        int         bad_ready = 0;
        int         bad_sel = 0;
        bit         acc_pending;
        logic [5:0] hdr = {dx, dy};

        if (dx == node_x && dy == node_y) begin
            chain[0] = PL; nchain = 1;
        end else begin
            if (dx != node_x) begin chain[nchain] = (dx > node_x) ? PE : PW; nchain++; end
            if (dy != node_y) begin chain[nchain] = (dy > node_y) ? PN : PS; nchain++; end
            chain[nchain] = PL; nchain++;
        end
        for (int c = 0; c < 32; c++) begin
            logic [4:0] p = chain[(c < nchain) ? c : nchain - 1];
            logic [4:0] f = free_mask & ~((c < pn_delay) ? PL : 5'b0);
            exp_tr[c] = p;
            if ((p & f) != 0) begin exp_len = c + 1; exp_sel = p; break; end
        end

        @(negedge clk);
        in_flit  = hdr;
        in_valid = 1'b1;
        free_now = free_mask & ~((pn_delay > 0) ? PL : 5'b0);
        #1;
        check(in_ready, "R2", "header accepted when idle", in_ready, 1);
        acc_pending = in_valid && in_ready;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (acc_pending) begin
                sent++;
                if (sent < PKT_LEN) in_flit = flit_of(hdr, sent);
                else in_valid = 1'b0;
            end
            free_now = free_mask & ~((c < pn_delay) ? PL : 5'b0);
            #1;
            if (!fwd_valid) begin
                if (obs_len < 32) obs_tr[obs_len] = out_req;
                obs_len++;
                if (in_ready) bad_ready++;
            end else begin
                if (nfwd == 0) sel_seen = out_sel;
                else if (out_sel != sel_seen || out_req != sel_seen) bad_sel++;
                if (fwd_flit != flit_of(hdr, nfwd)) bad_data++;
                nfwd++;
            end
            acc_pending = in_valid && in_ready;
            if (nfwd == PKT_LEN) break;
        end

        check(obs_len == exp_len, rq, "routing cycles before transfer", obs_len, exp_len);
        for (int i = 0; i < exp_len && i < obs_len; i++)
            check(obs_tr[i] == exp_tr[i], rq, "request in routing cycle",
                  obs_tr[i], exp_tr[i]);
        check(bad_ready == 0, "R2", "cycles accepting while routing", bad_ready, 0);
        check(sel_seen == exp_sel, "R8", "selected port", sel_seen, exp_sel);
        check(bad_sel == 0, "R8", "cycles with changed connection", bad_sel, 0);
        check(bad_data == 0, "R8", "flits out of order", bad_data, 0);
        check(nfwd == PKT_LEN, "R8", "flits forwarded", nfwd, PKT_LEN);

        @(negedge clk);
        #1;
        check(out_req == 0, "R9", "request after tail", out_req, 0);
        check(in_ready == 1'b1, "R9", "ready after tail", in_ready, 1);
        check(fwd_valid == 1'b0, "R9", "forward idle after tail", fwd_valid, 0);
        free_now = '0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        #1;
        check(out_req == 0, "R1", "request at reset", out_req, 0);
        check(fwd_valid == 0, "R1", "forward at reset", fwd_valid, 0);
        check(in_ready == 1, "R1", "ready at reset", in_ready, 1);
    endtask

    task automatic t_east_free();       // R3
        run_packet("R3", 3'd6, 3'd5, 5'b11111, 0);
    endtask

    task automatic t_west_busy_north(); // R4
        run_packet("R4", 3'd1, 3'd6, PN | PL, 0);
    endtask

    task automatic t_all_busy();        // R5
        run_packet("R5", 3'd5, 3'd1, PL | PW | PN, 0);
    endtask

    task automatic t_y_only();          // R4 R5
        run_packet("R4", 3'd3, 3'd0, PL | PE, 0);
    endtask

    task automatic t_x_only_busy();     // R4: no vertical attempt
        run_packet("R4", 3'd0, 3'd3, PL | PN | PS, 0);
    endtask

    task automatic t_local_dest();      // R6
        run_packet("R6", 3'd3, 3'd3, 5'b11111, 0);
    endtask

    task automatic t_eject_wait();      // R7
        run_packet("R7", 3'd7, 3'd7, PL, 6);
    endtask

    task automatic t_back_to_back();    // R9
        run_packet("R9", 3'd2, 3'd2, PW | PS, 0);
        run_packet("R9", 3'd4, 3'd3, PE, 0);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_east_free();
        t_west_busy_north();
        t_all_busy();
        t_y_only();
        t_x_only_busy();
        t_local_dest();
        t_eject_wait();
        t_back_to_back();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule